// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit settles a compare-and-branch instruction once its fields have been fetched and its source registers read. It is given the raw instruction word (right-aligned in a 96-bit bus), the address of the branch, and the two 64-bit register values. It evaluates a four-bit condition on the operands and decides whether the branch is taken. It then produces the address that fetch must continue from: the branch target when taken, or the fall-through address when not.

Three encodings are accepted, and the two low bits of the word select among them. A 24-bit short form tests one register against zero. A 48-bit form compares two registers with a 20-bit displacement. A 96-bit long form has the same layout as the 48-bit form, but its displacement is 68 bits wide. Displacements count 24-bit parcels, so each one is sign-extended and multiplied by three to give a byte offset. A flag in the wider forms makes the scaled displacement an absolute address instead of an offset from the branch. The result is registered and comes with a one-cycle valid strobe.

Top module: `cbr_resolve`

## Requirements
- R1: Synchronous active-high reset drives `out_valid`, `out_taken` and `out_target` to zero.
- R2: When `in_valid` is high and `insn[1:0]` is 00 (24-bit), 01 (48-bit) or 10 (96-bit), `out_valid` is high for exactly the next cycle. When `insn[1:0]` is 11, no strobe is produced.
- R3: In the 48-bit and 96-bit forms, `insn[12:9]` holds the condition. The codes are: 0 equal, 1 not equal, 6 always, 7 never. Codes 8 to 15 never take the branch.
- R4: Condition codes 2 (less than) and 3 (greater or equal) compare the operands as signed two's-complement values. Codes 4 (less than) and 5 (greater or equal) compare them as unsigned values. The comparison is always `rs_a` against `rs_b`.
- R5: A taken 48-bit branch with `insn[13]` clear targets `pc + 3*sext(insn[45:26])`.
- R6: A taken 48-bit or 96-bit branch with `insn[13]` set targets `3*sext(T)` alone, with no PC term.
- R7: A branch that is not taken outputs `pc + 3`, `pc + 6` or `pc + 12` for the 24-bit, 48-bit and 96-bit forms respectively.
- R8: The 96-bit form takes its displacement from `insn[93:26]`. Only the low 64 bits of that field contribute to the target.
- R9: The 24-bit form compares `rs_a` with zero. If `insn[2]` is 0 the branch is taken on equal; if it is 1, on not equal. Its displacement is `insn[23:15]`, sign-extended and scaled by three. It is always PC-relative.
- R10: All address arithmetic wraps modulo 2^64.
- R11: `out_taken` and `out_target` keep their values across cycles with no accepted instruction, including a cycle that presents the reserved length code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch instruction is presented this cycle |
| insn | input | 96 | Instruction word, right-aligned; shorter forms leave upper bits unused |
| pc | input | 64 | Byte address of the branch instruction |
| rs_a | input | 64 | First source register value |
| rs_b | input | 64 | Second source register value (unused by the short form) |
| out_valid | output | 1 | One-cycle strobe: result below is fresh |
| out_taken | output | 1 | The branch is taken |
| out_target | output | 64 | Next fetch address (target or fall-through) |

## Verification
The checker assumes that `in_valid` is the only qualifier of an instruction, so `insn` and `pc` are sampled only in the cycle the strobe refers to. It also assumes that no instruction is presented during reset. The bench drives each instruction for a single cycle and then drops `in_valid` before it samples the result, so every strobe maps to exactly one presented word. The bench keeps reset low while stimulus is active. It deliberately presents the reserved length code, which lets the hold property be exercised on a cycle where `in_valid` is high but nothing is accepted.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int XLEN        = 64;
    localparam int INSN_W      = 96;
    localparam int SHORT_T_W   = 9;
    localparam int MID_T_W     = 20;
    localparam int LONG_T_W    = 68;
    localparam int WIDE_T_LSB  = 26;
    localparam int SHORT_T_LSB = 15;
    localparam int COND_LSB    = 9;
    localparam int COND_W      = 4;
    localparam int ABS_BIT     = 13;
    localparam int SHORT_NE_BIT = 2;

    localparam int MID_T_MSB   = WIDE_T_LSB + MID_T_W - 1;
    localparam int LONG_T_MSB  = WIDE_T_LSB + LONG_T_W - 1;
    localparam int SHORT_T_MSB = SHORT_T_LSB + SHORT_T_W - 1;

    typedef enum logic [1:0] {
        FORM_SHORT = 2'b00,
        FORM_MID   = 2'b01,
        FORM_LONG  = 2'b10,
        FORM_RSVD  = 2'b11
    } form_e;

    typedef enum logic [COND_W-1:0] {
        CC_EQ     = 4'd0,
        CC_NE     = 4'd1,
        CC_LT     = 4'd2,
        CC_GE     = 4'd3,
        CC_LTU    = 4'd4,
        CC_GEU    = 4'd5,
        CC_ALWAYS = 4'd6,
        CC_NEVER  = 4'd7
    } cond_e;

    typedef struct packed {
        form_e             form;
        logic              legal;
        logic [COND_W-1:0] cond;
        logic              absolute;
        logic              zero_cmp;
        logic [XLEN-1:0]   disp;
    } br_fields_t;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] target;
    } br_result_t;

    // byte length of each instruction form
    function automatic logic [XLEN-1:0] form_bytes(form_e f);
        case (f)
            FORM_SHORT: form_bytes = XLEN'(3);
            FORM_MID:   form_bytes = XLEN'(6);
            FORM_LONG:  form_bytes = XLEN'(12);
            default:    form_bytes = '0;
        endcase
    endfunction

    // parcels to bytes: x*3 as shift plus add
    function automatic logic [XLEN-1:0] parcels_to_bytes(logic [XLEN-1:0] x);
        parcels_to_bytes = {x[XLEN-2:0], 1'b0} + x;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output br_fields_t        fields
);

    logic [SHORT_T_W-1:0] t_short;
    logic [MID_T_W-1:0]   t_mid;
    logic [LONG_T_W-1:0]  t_long;
    logic [XLEN-1:0]      disp_short;
    logic [XLEN-1:0]      disp_mid;
    logic [XLEN-1:0]      disp_long;

    assign t_short = insn[SHORT_T_MSB:SHORT_T_LSB];
    assign t_mid   = insn[MID_T_MSB:WIDE_T_LSB];
    assign t_long  = insn[LONG_T_MSB:WIDE_T_LSB];

    assign disp_short = {{(XLEN-SHORT_T_W){t_short[SHORT_T_W-1]}}, t_short};
    assign disp_mid   = {{(XLEN-MID_T_W){t_mid[MID_T_W-1]}}, t_mid};

    // the long field may exceed the address width: keep the low bits only
    generate
        if (LONG_T_W >= XLEN) begin : g_long_trunc
            assign disp_long = t_long[XLEN-1:0];
        end else begin : g_long_sext
            assign disp_long = {{(XLEN-LONG_T_W){t_long[LONG_T_W-1]}}, t_long};
        end
    endgenerate

    // opcode, register specifiers and pp bits are consumed elsewhere
    logic unused_decode_bits;
    assign unused_decode_bits = ^{insn[INSN_W-1:LONG_T_MSB+1], insn[8:3], insn[25:14]};

    always_comb begin
        fields          = '0;
        fields.form     = form_e'(insn[1:0]);
        fields.cond     = insn[COND_LSB+COND_W-1:COND_LSB];
        fields.absolute = insn[ABS_BIT];
        fields.legal    = 1'b1;
        case (form_e'(insn[1:0]))
            FORM_SHORT: begin
                fields.zero_cmp = 1'b1;
                fields.absolute = 1'b0;
                fields.cond     = insn[SHORT_NE_BIT] ? COND_W'(CC_NE) : COND_W'(CC_EQ);
                fields.disp     = disp_short;
            end
            FORM_MID: begin
                fields.disp = disp_mid;
            end
            FORM_LONG: begin
                fields.disp = disp_long;
            end
            default: begin
                fields.legal    = 1'b0;
                fields.cond     = COND_W'(CC_NEVER);
                fields.absolute = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
    import cbr_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              zero_cmp,
    input  logic [XLEN-1:0]   lhs,
    input  logic [XLEN-1:0]   rhs_reg,
    output logic              taken
);

    logic [XLEN-1:0] rhs;
    logic            eq;
    logic            lt_s;
    logic            lt_u;

    assign rhs  = zero_cmp ? '0 : rhs_reg;
    assign eq   = (lhs == rhs);
    assign lt_s = ($signed(lhs) < $signed(rhs));
    assign lt_u = (lhs < rhs);

    always_comb begin
        case (cond)
            CC_EQ:     taken = eq;
            CC_NE:     taken = !eq;
            CC_LT:     taken = lt_s;
            CC_GE:     taken = !lt_s;
            CC_LTU:    taken = lt_u;
            CC_GEU:    taken = !lt_u;
            CC_ALWAYS: taken = 1'b1;
            default:   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target
    import cbr_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  br_fields_t      fields,
    input  logic            taken,
    output logic [XLEN-1:0] next_addr
);

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] dest;
    logic [XLEN-1:0] fall;

    assign offset = parcels_to_bytes(fields.disp);
    assign dest   = fields.absolute ? offset : pc + offset;
    assign fall   = pc + form_bytes(fields.form);

    assign next_addr = taken ? dest : fall;

endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
    import cbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs_a,
    input  logic [XLEN-1:0]   rs_b,
    output logic              out_valid,
    output logic              out_taken,
    output logic [XLEN-1:0]   out_target
);

    br_fields_t fields;
    br_result_t res_d;
    br_result_t res_q;
    logic       accept;
    logic       valid_q;

    cbr_decode u_decode (
        .insn   (insn),
        .fields (fields)
    );

    cbr_cond u_cond (
        .cond     (fields.cond),
        .zero_cmp (fields.zero_cmp),
        .lhs      (rs_a),
        .rhs_reg  (rs_b),
        .taken    (res_d.taken)
    );

    cbr_target u_target (
        .pc        (pc),
        .fields    (fields),
        .taken     (res_d.taken),
        .next_addr (res_d.target)
    );

    assign accept = in_valid && fields.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_taken  = res_q.taken;
    assign out_target = res_q.target;

endmodule

// File: rtl/cbr_resolve_chk.sv
module cbr_resolve_chk
    import cbr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [INSN_W-1:0] insn,
    input logic [XLEN-1:0]   pc,
    input logic              out_valid,
    input logic              out_taken,
    input logic [XLEN-1:0]   out_target
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_taken && out_target == '0));

    // R2
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == ($past(in_valid) && ($past(insn[1:0]) != 2'b11))));

    // R3
    cond_always_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[1:0] != 2'b00 && insn[1:0] != 2'b11 && insn[12:9] == 4'd6) |=> out_taken);

    // R3
    cond_never_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[1:0] != 2'b00 && insn[1:0] != 2'b11 && insn[12:9] >= 4'd7) |=> !out_taken);

    // R7
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_taken) |->
            out_target == $past(pc) + (($past(insn[1:0]) == 2'b00) ? 64'd3 :
                                       ($past(insn[1:0]) == 2'b01) ? 64'd6 : 64'd12));

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || insn[1:0] == 2'b11) |=> ($stable(out_taken) && $stable(out_target)));

endmodule

bind cbr_resolve cbr_resolve_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .insn       (insn),
    .pc         (pc),
    .out_valid  (out_valid),
    .out_taken  (out_taken),
    .out_target (out_target)
);

// File: tb/cbr_resolve_bench.sv
module cbr_resolve_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [95:0] insn;
    logic [63:0] pc;
    logic [63:0] rs_a;
    logic [63:0] rs_b;
    logic        out_valid;
    logic        out_taken;
    logic [63:0] out_target;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cbr_resolve u_cbr_resolve (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
        .rs_a(rs_a), .rs_b(rs_b), .out_valid(out_valid),
        .out_taken(out_taken), .out_target(out_target)
    );

    function automatic logic [95:0] mk_mid(logic [19:0] t, logic [5:0] ra, logic [5:0] rb,
                                          logic ab, logic [3:0] cc);
        mk_mid = {48'b0, 2'b00, t, ra, rb, ab, cc, 7'h15, 2'b01};
    endfunction

    function automatic logic [95:0] mk_long(logic [67:0] t, logic ab, logic [3:0] cc);
        mk_long = {2'b00, t, 6'd3, 6'd4, ab, cc, 7'h15, 2'b10};
    endfunction

    function automatic logic [95:0] mk_short(logic [8:0] t, logic ne);
        mk_short = {72'b0, t, 6'd5, 6'h2A, ne, 2'b00};
    endfunction

    function automatic bit ref_cond(logic [3:0] cc, logic [63:0] a, logic [63:0] b);
        case (cc)
            4'd0: ref_cond = (a == b);
            4'd1: ref_cond = (a != b);
            4'd2: ref_cond = ($signed(a) < $signed(b));
            4'd3: ref_cond = ($signed(a) >= $signed(b));
            4'd4: ref_cond = (a < b);
            4'd5: ref_cond = (a >= b);
            4'd6: ref_cond = 1'b1;
            default: ref_cond = 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present one word for one cycle, leave outputs ready to sample at the negedge
    task automatic issue(logic [95:0] w, logic [63:0] p, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; insn = w; pc = p; rs_a = a; rs_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_result(string req, bit tk, logic [63:0] tg);
        check(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
        check(out_taken == tk, req, 64'(out_taken), 64'(tk));
        check(out_target == tg, req, out_target, tg);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; insn = '0; pc = '0; rs_a = '0; rs_b = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_taken && out_target == 0, "R1", out_target, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_conditions();
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] p;
        for (int pat = 0; pat < 3; pat++) begin
            a = (pat == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (pat == 1) ? 64'd7 : 64'd9;
            b = (pat == 0) ? 64'd1 : (pat == 1) ? 64'd7 : 64'h8000_0000_0000_0000;
            for (int cc = 0; cc < 16; cc++) begin
                bit tk;
                p  = 64'h1000 + 64'(cc * 64);
                tk = ref_cond(4'(cc), a, b);
                issue(mk_mid(20'd10, 6'd1, 6'd2, 1'b0, 4'(cc)), p, a, b);
                expect_result((cc >= 2 && cc <= 5) ? "R4" : "R3", tk,
                              tk ? p + 64'd30 : p + 64'd6);
            end
        end
    endtask

    task automatic t_relative();
        // displacement -4 parcels -> -12 bytes
        issue(mk_mid(20'hFFFFC, 6'd1, 6'd2, 1'b0, 4'd6), 64'h2000, 0, 0);
        expect_result("R5", 1'b1, 64'h2000 - 64'd12);
        // largest positive displacement
        issue(mk_mid(20'h7FFFF, 6'd1, 6'd2, 1'b0, 4'd6), 64'h10, 0, 0);
        expect_result("R5", 1'b1, 64'h10 + 64'h7FFFF * 3);
    endtask

    task automatic t_absolute();
        issue(mk_mid(20'd100, 6'd1, 6'd2, 1'b1, 4'd0), 64'hABCD_0000, 5, 5);
        expect_result("R6", 1'b1, 64'd300);
        issue(mk_mid(20'hFFFFF, 6'd1, 6'd2, 1'b1, 4'd6), 64'h5000, 0, 0);
        expect_result("R6", 1'b1, 64'hFFFF_FFFF_FFFF_FFFD);
        issue(mk_long(68'h0_0000_0000_0001_0000, 1'b1, 4'd6), 64'h9000, 0, 0);
        expect_result("R6", 1'b1, 64'h30000);
    endtask

    task automatic t_fallthrough();
        issue(mk_mid(20'd50, 6'd1, 6'd2, 1'b0, 4'd7), 64'h400, 0, 0);
        expect_result("R7", 1'b0, 64'h406);
        issue(mk_long(68'd50, 1'b0, 4'd7), 64'h400, 0, 0);
        expect_result("R7", 1'b0, 64'h40C);
        issue(mk_short(9'd50, 1'b0), 64'h400, 64'd1, 0);
        expect_result("R7", 1'b0, 64'h403);
    endtask

    task automatic t_long();
        // upper four field bits lie beyond the address width and must not matter
        issue(mk_long({4'hA, 64'h0000_0000_0000_0100}, 1'b0, 4'd6), 64'h8000, 0, 0);
        expect_result("R8", 1'b1, 64'h8000 + 64'h300);
        issue(mk_long({4'h5, 64'hFFFF_FFFF_FFFF_FFFE}, 1'b0, 4'd1), 64'h8000, 1, 2);
        expect_result("R8", 1'b1, 64'h8000 - 64'd6);
    endtask

    task automatic t_short();
        issue(mk_short(9'd8, 1'b0), 64'h600, 64'd0, 64'd99);
        expect_result("R9", 1'b1, 64'h600 + 64'd24);
        issue(mk_short(9'd8, 1'b1), 64'h600, 64'd0, 64'd99);
        expect_result("R9", 1'b0, 64'h603);
        issue(mk_short(9'h1FF, 1'b1), 64'h600, 64'd4, 64'd4);
        expect_result("R9", 1'b1, 64'h600 - 64'd3);
        issue(mk_short(9'h100, 1'b0), 64'h600, 64'd0, 64'd1);
        expect_result("R9", 1'b1, 64'h600 - 64'd768);
    endtask

    task automatic t_wrap();
        issue(mk_long(68'd7, 1'b0, 4'd7), 64'hFFFF_FFFF_FFFF_FFF8, 0, 0);
        expect_result("R10", 1'b0, 64'h4);
        issue(mk_mid(20'd2, 6'd1, 6'd2, 1'b0, 4'd6), 64'hFFFF_FFFF_FFFF_FFFE, 0, 0);
        expect_result("R10", 1'b1, 64'h4);
    endtask

    task automatic t_reserved_and_hold();
        logic [63:0] held;
        issue(mk_mid(20'd1, 6'd1, 6'd2, 1'b0, 4'd6), 64'h700, 0, 0);
        expect_result("R11", 1'b1, 64'h703);
        held = out_target;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", 64'(out_valid), 64'd0);
        check(out_taken == 1'b1 && out_target == held, "R11", out_target, held);
        // reserved length code: no strobe and no change
        issue({mk_mid(20'd40, 6'd1, 6'd2, 1'b0, 4'd7)} | 96'h3, 64'hF00, 0, 0);
        check(out_valid == 1'b0, "R2", 64'(out_valid), 64'd0);
        check(out_taken == 1'b1 && out_target == held, "R11", out_target, held);
        repeat (3) @(negedge clk);
        check(out_target == held, "R11", out_target, held);
    endtask

    initial begin
        t_reset();
        t_conditions();
        t_relative();
        t_absolute();
        t_fallthrough();
        t_long();
        t_short();
        t_wrap();
        t_reserved_and_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule